// File: doc/BRIEF.md
# Host IO Register Port for a Byte Link

This block sits on a Z80-style IO bus as a slave. It gives the host two registers for a pair of byte FIFOs. One FIFO carries bytes from the host to a coprocessor, the other carries bytes back. The FIFO storage is outside the block. The block only decodes the bus, muxes read data and generates the strobes that move bytes.

The address decode is partial. Every 16-bit IO address from 0xFD80 to 0xFD87 selects the block. Address bit 0 picks the register: even addresses reach the data register and odd addresses reach the status register.

- Reading the data register takes the head byte of the inbound FIFO.
- Writing the data register offers a byte to the outbound FIFO.
- Reading the status register returns two flags: space toward the coprocessor, and a byte waiting for the host.
- Writing the status register with any value clears both FIFOs.

The bus signals are sampled on the block clock. Each IO cycle yields exactly one strobe, raised after the cycle ends.

The FIFO side uses valid/ready naming. The outbound port raises `tx_valid` for exactly one clock per data write, and the byte is taken only if `tx_ready` is high in that clock. There is no holding: a full FIFO makes the byte drop. The inbound port raises `rx_ready` for one clock per data read, and the byte is removed only if `rx_valid` is high in that clock. A read of an empty FIFO therefore moves nothing.

Top module: `hostio_fifo_regs`

## Requirements
- R1: The block responds only while `iorq_n`=0, `m1_n`=1 and `addr[15:3]`=0x1FB0 (addresses 0xFD80 to 0xFD87). Any other access causes no output enable and no strobe.
- R2: The register choice depends only on `addr[0]` (0 = data, 1 = status). Addresses 0xFD80, 0xFD82, 0xFD84 and 0xFD86 behave identically, and so do the odd addresses in the window.
- R3: While a status read is active, `data_oe`=8'b0000_0011. `data_out[1]` equals `tx_ready` and `data_out[0]` equals `rx_valid`. Bits 7..2 are not enabled.
- R4: While a data read is active, `data_oe`=8'hFF and `data_out` equals `rx_data`. `rx_ready` pulses for one clock, starting one clock after the first clock edge that samples the cycle as ended.
- R5: A data write presents on `tx_data` the `data_in` value sampled at the last active clock edge. `tx_valid` pulses for one clock, with the same timing as R4.
- R6: A status write of any value pulses `fifo_clear` for one clock, with the timing of R4, and raises no push or pop.
- R7: Each IO cycle gives exactly one strobe, however many clocks it lasts. At most one of `tx_valid`, `rx_ready` and `fifo_clear` is high in any clock.
- R8: A data write while `tx_ready`=0 leaves the outbound FIFO unchanged. A data read while `rx_valid`=0 leaves the inbound FIFO unchanged, and its data is undefined.
- R9: While `rst_n`=0, and in the first clock after it rises, `tx_valid`, `rx_ready` and `fifo_clear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus signals are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | IO address |
| iorq_n | input | 1 | IO request, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Bus write data |
| data_out | output | 8 | Bus read data |
| data_oe | output | 8 | Per-bit output enable for the bus tristate |
| tx_valid | output | 1 | One-clock offer of a byte to the outbound FIFO |
| tx_ready | input | 1 | Outbound FIFO has space |
| tx_data | output | 8 | Byte offered to the outbound FIFO |
| rx_valid | input | 1 | Inbound FIFO holds a byte |
| rx_ready | output | 1 | One-clock pop of the inbound FIFO |
| rx_data | input | 8 | Head byte of the inbound FIFO |
| fifo_clear | output | 1 | One-clock clear of both FIFOs |

## Verification
The bench builds the block with its default parameters: window base 0xFD80, three ignored low address bits and 8-bit data. It attaches FIFO models four entries deep. A depth of four lets a few writes reach the full condition, so a dropped push can be seen. Reads past a three-byte preload reach the empty condition. Accesses at 0xFD7F and 0xFD88 probe both edges of the window. An acknowledge-style access is also run, and a long IO cycle checks that it gives a single strobe.

// File: rtl/hfr_pkg.sv
package hfr_pkg;
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_RD_DATA = 3'd1,
    ACC_RD_STAT = 3'd2,
    ACC_WR_DATA = 3'd3,
    ACC_WR_STAT = 3'd4
  } acc_kind_e;
endpackage

// File: rtl/hfr_decode.sv
module hfr_decode
  import hfr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFD80,
  parameter int WIN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output acc_kind_e         kind
);
  localparam int CMP_LO = WIN_BITS;

  logic hit;
  assign hit = !iorq_n && m1_n && (addr[ADDR_W-1:CMP_LO] == WIN_BASE[ADDR_W-1:CMP_LO]);

  always_comb begin
    kind = ACC_NONE;
    if (hit && !rd_n)      kind = addr[0] ? ACC_RD_STAT : ACC_RD_DATA;
    else if (hit && !wr_n) kind = addr[0] ? ACC_WR_STAT : ACC_WR_DATA;
  end
endmodule

// File: rtl/hfr_strobe.sv
module hfr_strobe
  import hfr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] data_in,
  output logic              push,
  output logic              pop,
  output logic              clear,
  output logic [DATA_W-1:0] push_data
);
  acc_kind_e kind_q;
  logic      ended;

  assign ended = (kind_q != ACC_NONE) && (kind != kind_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= ACC_NONE;
      push      <= 1'b0;
      pop       <= 1'b0;
      clear     <= 1'b0;
      push_data <= '0;
    end else begin
      kind_q <= kind;
      push   <= ended && (kind_q == ACC_WR_DATA);
      pop    <= ended && (kind_q == ACC_RD_DATA);
      clear  <= ended && (kind_q == ACC_WR_STAT);
      if (kind == ACC_WR_DATA) push_data <= data_in;
    end
  end
endmodule

// File: rtl/hfr_rdmux.sv
module hfr_rdmux
  import hfr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIR_BIT = 1,
  parameter int DOR_BIT = 0
) (
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe
);
  logic rd_dat, rd_sta;
  assign rd_dat = (kind == ACC_RD_DATA);
  assign rd_sta = (kind == ACC_RD_STAT);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == DIR_BIT) begin : g_dir
      assign data_out[i] = rd_sta ? tx_ready : rx_data[i];
      assign data_oe[i]  = rd_dat || rd_sta;
    end else if (i == DOR_BIT) begin : g_dor
      assign data_out[i] = rd_sta ? rx_valid : rx_data[i];
      assign data_oe[i]  = rd_dat || rd_sta;
    end else begin : g_plain
      assign data_out[i] = rx_data[i];
      assign data_oe[i]  = rd_dat;
    end
  end
endmodule

// File: rtl/hostio_fifo_regs.sv
module hostio_fifo_regs
  import hfr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFD80,
  parameter int WIN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              fifo_clear
);
  acc_kind_e kind;

  hfr_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)) u_dec (
    .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .kind(kind)
  );

  hfr_strobe #(.DATA_W(DATA_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .kind(kind), .data_in(data_in),
    .push(tx_valid), .pop(rx_ready), .clear(fifo_clear), .push_data(tx_data)
  );

  hfr_rdmux #(.DATA_W(DATA_W)) u_mux (
    .kind(kind), .rx_data(rx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .data_out(data_out), .data_oe(data_oe)
  );
endmodule

// File: rtl/hfr_checker.sv
module hfr_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              iorq_n,
  input logic              m1_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] data_out,
  input logic [DATA_W-1:0] data_oe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              fifo_clear
);
  // R1: no bus drive without a qualified read
  a_r1_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n || !m1_n || rd_n) |-> (data_oe == '0));

  // R3: status flags follow the FIFO flags
  a_r3_status_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe == 8'h03) |-> (data_out[1:0] == {tx_ready, rx_valid}));

  // R7: one strobe at a time
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready, fifo_clear}));

  // R7: strobes last a single clock
  a_r7_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  a_r7_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);
  a_r7_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> !fifo_clear);

  // R4: a pop follows a data read
  a_r4_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> $past(data_oe == 8'hFF, 2));

  // R5: a push follows a data write
  a_r5_push_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(!iorq_n && m1_n && !wr_n && !addr[0], 2));

  // R6: a clear follows a status write
  a_r6_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> $past(!iorq_n && m1_n && !wr_n && addr[0], 2));
endmodule

bind hostio_fifo_regs hfr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/hostio_fifo_regs_test.sv
`timescale 1ns/1ps
module hostio_fifo_regs_test;
  localparam int DEPTH = 4;
  localparam int K_NONE = 0, K_RDD = 1, K_RDS = 2, K_WRD = 3, K_WRS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out, data_oe, tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, rx_ready, fifo_clear;

  int checks = 0, failures = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  int prev_k = K_NONE;
  logic e_push = 0, e_pop = 0, e_clr = 0;
  logic [7:0] e_wdat = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;

  hostio_fifo_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .fifo_clear(fifo_clear)
  );

  assign tx_ready = (tx_q.size() < DEPTH);
  assign rx_valid = (rx_q.size() > 0);
  assign rx_data  = (rx_q.size() > 0) ? rx_q[0] : 8'h00;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int classify();
    if (iorq_n || !m1_n || (addr < 16'hFD80) || (addr > 16'hFD87)) return K_NONE;
    if (!rd_n) return addr[0] ? K_RDS : K_RDD;
    if (!wr_n) return addr[0] ? K_WRS : K_WRD;
    return K_NONE;
  endfunction

  // reference model of strobe timing
  always @(posedge clk) begin
    int k;
    k = classify();
    if (!rst_n) begin
      prev_k <= K_NONE; e_push <= 0; e_pop <= 0; e_clr <= 0;
    end else begin
      e_push <= (prev_k == K_WRD) && (k != K_WRD);
      e_pop  <= (prev_k == K_RDD) && (k != K_RDD);
      e_clr  <= (prev_k == K_WRS) && (k != K_WRS);
      if (k == K_WRD) e_wdat <= data_in;
      prev_k <= k;
    end
  end

  // FIFO models and per-cycle comparison
  always begin
    int k;
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R7 push strobe", tx_valid, e_push);
      chk("R4 pop strobe", rx_ready, e_pop);
      chk("R6 clear strobe", fifo_clear, e_clr);
      if (e_push) chk("R5 push data", tx_data, e_wdat);
      if (fifo_clear) begin tx_q.delete(); rx_q.delete(); end
      else begin
        if (tx_valid && tx_ready) tx_q.push_back(tx_data);
        if (rx_ready && rx_valid) void'(rx_q.pop_front());
      end
      #1;
      k = classify();
      chk("R1 output enable", data_oe,
          (k == K_RDD) ? 8'hFF : (k == K_RDS) ? 8'h03 : 8'h00);
      if (k == K_RDD && rx_valid) chk("R4 read data", data_out, rx_data);
      if (k == K_RDS) chk("R3 status bits", data_out[1:0], {tx_ready, rx_valid});
    end
  end

  task automatic io(input bit is_wr, input logic [15:0] a, input logic [7:0] d,
                    input logic m1v, input int nclk, output logic [7:0] rdv);
    @(negedge clk);
    addr = a; data_in = d; m1_n = m1v; iorq_n = 1'b0;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    for (int i = 0; i < nclk; i++) @(negedge clk);
    #3 rdv = data_out;
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rx_q.push_back(8'hA5); rx_q.push_back(8'h3C); rx_q.push_back(8'h7E);
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset push", tx_valid, 0);
    chk("R9 reset pop", rx_ready, 0);
    chk("R9 reset clear", fifo_clear, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R9 first clock after reset", {tx_valid, rx_ready, fifo_clear}, 3'b000);

    // R5 / R2: writes through aliased even addresses
    io(1, 16'hFD80, 8'h11, 1, 1, r);
    io(1, 16'hFD86, 8'h22, 1, 2, r);
    chk("R5 tx count", tx_q.size(), 2);
    chk("R2 alias write", tx_q[1], 8'h22);
    // R1: outside window and acknowledge cycle ignored
    io(1, 16'hFD88, 8'h33, 1, 1, r);
    io(1, 16'hFD7F, 8'h44, 1, 1, r);
    io(1, 16'hFD80, 8'h55, 0, 1, r);
    chk("R1 ignored accesses", tx_q.size(), 2);
    // R3: status read via an aliased odd address
    io(0, 16'hFD85, 8'h00, 1, 1, r);
    chk("R3 status value", r[1:0], 2'b11);
    // R4: data reads return the FIFO head and pop
    io(0, 16'hFD80, 8'h00, 1, 1, r);
    chk("R4 first byte", r, 8'hA5);
    io(0, 16'hFD82, 8'h00, 1, 3, r);
    chk("R4 second byte", r, 8'h3C);
    chk("R4 rx count", rx_q.size(), 1);
    // R7: a long write cycle gives one push
    io(1, 16'hFD84, 8'h66, 1, 6, r);
    chk("R7 single push", tx_q.size(), 3);
    // R8: full FIFO drops writes
    io(1, 16'hFD80, 8'h77, 1, 1, r);
    io(1, 16'hFD80, 8'h88, 1, 1, r);
    chk("R8 full count", tx_q.size(), DEPTH);
    chk("R8 last kept", tx_q[DEPTH-1], 8'h77);
    io(0, 16'hFD81, 8'h00, 1, 1, r);
    chk("R3 status full", r[1:0], 2'b01);
    // R8: read empty moves nothing
    io(0, 16'hFD80, 8'h00, 1, 1, r);
    io(0, 16'hFD80, 8'h00, 1, 1, r);
    chk("R8 empty count", rx_q.size(), 0);
    io(0, 16'hFD83, 8'h00, 1, 1, r);
    chk("R3 status empty", r[1:0], 2'b00);
    // R6: status write clears
    rx_q.push_back(8'h99);
    io(1, 16'hFD87, 8'h5A, 1, 2, r);
    chk("R6 tx cleared", tx_q.size(), 0);
    chk("R6 rx cleared", rx_q.size(), 0);
    io(0, 16'hFD81, 8'h00, 1, 1, r);
    chk("R6 status after clear", r[1:0], 2'b10);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule